// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit device virtual address into a physical address. It reads one or two words of a two-level translation table held in memory. A client presents a request with the address and the access direction. The walker then reads the first-level descriptor at the table base plus four times the top twelve address bits. The descriptor either maps a 1 MB region directly, points at a 256-entry second-level table, or marks a fault. A second-level descriptor maps a 64 KB or a 4 KB page, or marks a fault.

Each walk ends with a single-cycle completion strobe. The strobe carries either the physical address or a fault flag. With a fault, the walker also gives the faulting virtual address and the read/write direction, so a fault handler can pick the right fault register. Memory is reached through a plain word-read port: a one-cycle read strobe with an address, then a response strobe with data some cycles later. Only one walk is in flight at a time.

Top module: `pt_walker`

## Requirements
- R1: After reset, `busy`, `done` and `mem_rd_valid` are low.
- R2: The first read of a walk goes to `ptbase + 4*req_vaddr[31:20]`.
- R3: A first-level descriptor whose bits [1:0] are 00 or 11 ends the walk after that single read with `done_fault`=1. `fault_vaddr` is the request address and `fault_write` is the request direction.
- R4: A first-level descriptor with bits [1:0]=10 ends the walk after one read with physical address `{desc[31:20], va[19:0]}`.
- R5: A first-level descriptor with bits [1:0]=01 causes a second read at `{desc[31:10],10'b0} + 4*va[19:12]`.
- R6: A second-level descriptor with bits [1:0]=00 ends the walk with `done_fault`=1 after two reads.
- R7: A second-level descriptor with bits [1:0]=01 gives physical address `{desc[31:16], va[15:0]}`.
- R8: A second-level descriptor with bit 1 set (10 or 11) gives physical address `{desc[31:12], va[11:0]}`.
- R9: A 64 KB page that is replicated in its 16 second-level slots resolves to the same page base from any address inside it.
- R10: `busy` rises the cycle after an accepted request and stays high up to and including the one-cycle `done` pulse. A request presented while busy is ignored.
- R11: `mem_rd_valid` is a one-cycle pulse, only during a walk. At most one read is outstanding, so the walker waits for the response however long it takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request, taken when not busy |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| ptbase | input | 32 | First-level table base address |
| busy | output | 1 | Walk in progress |
| mem_rd_valid | output | 1 | One-cycle word read strobe |
| mem_rd_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 32 | Read data (descriptor) |
| done | output | 1 | One-cycle walk completion |
| done_fault | output | 1 | Walk ended in a fault |
| done_paddr | output | 32 | Translated physical address |
| fault_vaddr | output | 32 | Virtual address of the walk |
| fault_write | output | 1 | Direction of the walk |

## Verification
Walks are run with descriptors of every type code at both levels. This shows that 00 and 11 at level one both fault, while 10 and 11 at level two both map a small page. The tests count reads per walk, which tells a one-level walk from a two-level one. They also compare read addresses to find index and base errors. A large page is probed at two different slots, a fault is taken on a write, and a longer memory latency plus a request presented mid-walk check the one-at-a-time handshake.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int WORD_W     = 32;
  localparam int SECT_SH    = 20;  // 1 MB
  localparam int LARGE_SH   = 16;  // 64 KB
  localparam int SMALL_SH   = 12;  // 4 KB
  localparam int L2_BASE_SH = 10;
  localparam int ENT_SH     = 2;   // 4-byte descriptors
  localparam int L2_IDX_W   = SECT_SH - SMALL_SH;

  typedef logic [WORD_W-1:0] word_t;
  typedef enum logic [1:0] {K1_FAULT, K1_TABLE, K1_SECT} l1_kind_e;
  typedef enum logic [1:0] {K2_FAULT, K2_LARGE, K2_SMALL} l2_kind_e;

  function automatic word_t low_mask(int sh);
    return (word_t'(1) << sh) - word_t'(1);
  endfunction

  function automatic word_t splice(word_t desc, word_t va, int sh);
    return (desc & ~low_mask(sh)) | (va & low_mask(sh));
  endfunction

  function automatic word_t l1_addr(word_t base, word_t va);
    return base + ((va >> SECT_SH) << ENT_SH);
  endfunction

  function automatic word_t l2_addr(word_t desc, word_t va);
    word_t idx;
    idx = (va >> SMALL_SH) & low_mask(L2_IDX_W);
    return (desc & ~low_mask(L2_BASE_SH)) + (idx << ENT_SH);
  endfunction

  function automatic l1_kind_e l1_kind(word_t desc);
    case (desc[1:0])
      2'b01:   return K1_TABLE;
      2'b10:   return K1_SECT;
      default: return K1_FAULT;
    endcase
  endfunction

  function automatic l2_kind_e l2_kind(word_t desc);
    if (desc[1])      return K2_SMALL;
    else if (desc[0]) return K2_LARGE;
    else              return K2_FAULT;
  endfunction
endpackage

// File: rtl/ptw_l1_decode.sv
module ptw_l1_decode
  import ptw_pkg::*;
(
  input  word_t    desc,
  input  word_t    va,
  output l1_kind_e kind,
  output word_t    sect_pa,
  output word_t    next_addr
);
  assign kind      = l1_kind(desc);
  assign sect_pa   = splice(desc, va, SECT_SH);
  assign next_addr = l2_addr(desc, va);
endmodule

// File: rtl/ptw_l2_decode.sv
module ptw_l2_decode
  import ptw_pkg::*;
(
  input  word_t    desc,
  input  word_t    va,
  output l2_kind_e kind,
  output word_t    pa
);
  assign kind = l2_kind(desc);
  assign pa   = (kind == K2_LARGE) ? splice(desc, va, LARGE_SH)
                                   : splice(desc, va, SMALL_SH);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_vaddr,
  input  logic        req_write,
  input  logic [31:0] ptbase,
  output logic        busy,
  output logic        mem_rd_valid,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output logic        done,
  output logic        done_fault,
  output logic [31:0] done_paddr,
  output logic [31:0] fault_vaddr,
  output logic        fault_write
);
  typedef enum logic [2:0] {S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_FIN} state_e;

  state_e   state;
  word_t    va_q, base_q, l2a_q, pa_q;
  logic     wr_q, fault_q;

  l1_kind_e k1;
  l2_kind_e k2;
  word_t    sect_pa, next_addr, page_pa;

  ptw_l1_decode u_l1 (.desc(mem_rsp_data), .va(va_q), .kind(k1),
                      .sect_pa(sect_pa), .next_addr(next_addr));
  ptw_l2_decode u_l2 (.desc(mem_rsp_data), .va(va_q), .kind(k2), .pa(page_pa));

  // named events for the checker
  logic l1_rsp, l2_rsp, l1_rsp_fault, l1_rsp_sect, l2_rsp_fault;
  assign l1_rsp       = (state == S_L1_WAIT) && mem_rsp_valid;
  assign l2_rsp       = (state == S_L2_WAIT) && mem_rsp_valid;
  assign l1_rsp_fault = l1_rsp && (k1 == K1_FAULT);
  assign l1_rsp_sect  = l1_rsp && (k1 == K1_SECT);
  assign l2_rsp_fault = l2_rsp && (k2 == K2_FAULT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      va_q    <= '0;
      base_q  <= '0;
      l2a_q   <= '0;
      pa_q    <= '0;
      wr_q    <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          va_q    <= req_vaddr;
          wr_q    <= req_write;
          base_q  <= ptbase;
          fault_q <= 1'b0;
          pa_q    <= '0;
          state   <= S_L1_REQ;
        end
        S_L1_REQ: state <= S_L1_WAIT;
        S_L1_WAIT: if (mem_rsp_valid) begin
          case (k1)
            K1_SECT:  begin pa_q <= sect_pa; state <= S_FIN; end
            K1_TABLE: begin l2a_q <= next_addr; state <= S_L2_REQ; end
            default:  begin fault_q <= 1'b1; state <= S_FIN; end
          endcase
        end
        S_L2_REQ: state <= S_L2_WAIT;
        S_L2_WAIT: if (mem_rsp_valid) begin
          if (k2 == K2_FAULT) fault_q <= 1'b1;
          else                pa_q    <= page_pa;
          state <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy         = (state != S_IDLE);
  assign done         = (state == S_FIN);
  assign mem_rd_valid = (state == S_L1_REQ) || (state == S_L2_REQ);
  assign mem_rd_addr  = (state == S_L2_REQ) ? l2a_q : l1_addr(base_q, va_q);
  assign done_fault   = fault_q;
  assign done_paddr   = pa_q;
  assign fault_vaddr  = va_q;
  assign fault_write  = wr_q;
endmodule

// File: rtl/ptw_chk.sv
module ptw_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        busy,
  input logic        done,
  input logic        done_fault,
  input logic        mem_rd_valid,
  input logic [31:0] fault_vaddr,
  input logic        l1_rsp_fault,
  input logic        l1_rsp_sect,
  input logic        l2_rsp_fault
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy); // R10
  AST_START_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(req_valid)); // R10
  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) mem_rd_valid |=> !mem_rd_valid); // R11
  AST_RD_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n) mem_rd_valid |-> busy); // R11
  AST_L1_FAULT_END: assert property (@(posedge clk) disable iff (!rst_n) l1_rsp_fault |=> done && done_fault); // R3
  AST_VADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n) busy && $past(busy) |-> $stable(fault_vaddr)); // R3
  AST_SECT_END: assert property (@(posedge clk) disable iff (!rst_n) l1_rsp_sect |=> done && !done_fault && !mem_rd_valid); // R4
  AST_L2_FAULT_END: assert property (@(posedge clk) disable iff (!rst_n) l2_rsp_fault |=> done && done_fault); // R6
endmodule

bind pt_walker ptw_chk u_chk (.*);

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic [31:0] ptbase = '0;
  logic        busy, mem_rd_valid, done, done_fault, fault_write;
  logic [31:0] mem_rd_addr, done_paddr, fault_vaddr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int checks = 0;
  int fails  = 0;
  int rd_count = 0;
  int mlat = 1;
  logic [31:0] last_rd [2];
  logic [31:0] mem [int unsigned];

  // results of the latest walk
  logic [31:0] r_pa, r_fva;
  logic        r_fault, r_fwr;
  int          r_reads;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker u0 (.*);

  // memory model: fixed latency, one read at a time
  int lat_cnt = 0;
  logic [31:0] pend_addr = '0;
  always @(negedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (lat_cnt > 0) begin
      lat_cnt = lat_cnt - 1;
      if (lat_cnt == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem.exists(pend_addr) ? mem[pend_addr] : 32'h0;
      end
    end
    if (mem_rd_valid) begin
      pend_addr = mem_rd_addr;
      last_rd[rd_count % 2] = mem_rd_addr;
      rd_count = rd_count + 1;
      lat_cnt = mlat;
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] va, input logic wr);
    int r0 = rd_count;
    logic got = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 500 && !got; i++) begin
      if (done) begin
        got = 1'b1;
        r_pa = done_paddr; r_fault = done_fault; r_fva = fault_vaddr; r_fwr = fault_write;
        r_reads = rd_count - r0;
      end else @(negedge clk);
    end
    check(got, "R10 walk completes", {31'b0, got}, 32'h1);
    @(negedge clk);
    check(!done && !busy, "R10 done is a single pulse", {30'b0, done, busy}, 32'h0);
  endtask

  task automatic t_reset();
    check(!busy && !done && !mem_rd_valid, "R1 reset state", {29'b0, busy, done, mem_rd_valid}, 32'h0);
  endtask

  task automatic t_section();
    mem[32'h0001_0000 + 32'h123*4] = 32'hABC0_0002;
    walk(32'h1234_5678, 1'b0);
    check(last_rd[(rd_count-1)%2] == 32'h0001_048C, "R2 level-one read address", last_rd[(rd_count-1)%2], 32'h0001_048C);
    check(!r_fault && r_pa == 32'hABC4_5678, "R4 section address", r_pa, 32'hABC4_5678);
    check(r_reads == 1, "R4 one read for a section", r_reads, 1);
  endtask

  task automatic t_l1_fault();
    walk(32'h0077_0010, 1'b1);
    check(r_fault && r_reads == 1, "R3 code 00 faults after one read", {r_fault, 31'(r_reads)}, 32'h8000_0001);
    check(r_fva == 32'h0077_0010 && r_fwr, "R3 fault address and write", r_fva, 32'h0077_0010);
    mem[32'h0001_0000 + 32'h055*4] = 32'h5555_5557;
    walk(32'h0551_2340, 1'b0);
    check(r_fault && r_reads == 1, "R3 code 11 faults", {r_fault, 31'(r_reads)}, 32'h8000_0001);
    check(r_fva == 32'h0551_2340 && !r_fwr, "R3 fault address and read", {r_fva[31:1], r_fwr}, 32'h0551_2340);
  endtask

  task automatic t_small();
    mem[32'h0001_0000 + 32'h200*4] = 32'h0040_0401;
    mem[32'h0040_04D0] = 32'h7777_7002;
    walk(32'h2003_4ABC, 1'b0);
    check(r_reads == 2 && last_rd[(rd_count-1)%2] == 32'h0040_04D0, "R5 level-two read address", last_rd[(rd_count-1)%2], 32'h0040_04D0);
    check(!r_fault && r_pa == 32'h7777_7ABC, "R8 small page code 10", r_pa, 32'h7777_7ABC);
    mem[32'h0040_04D4] = 32'h8888_8003;
    walk(32'h2003_5001, 1'b1);
    check(!r_fault && r_pa == 32'h8888_8001, "R8 small page code 11", r_pa, 32'h8888_8001);
  endtask

  task automatic t_large();
    mem[32'h0001_0000 + 32'h300*4] = 32'h0050_0001;
    for (int s = 16; s < 32; s++) mem[32'h0050_0000 + s*4] = 32'h9999_0001;
    walk(32'h3001_2345, 1'b0);
    check(!r_fault && r_pa == 32'h9999_2345, "R7 large page", r_pa, 32'h9999_2345);
    walk(32'h3001_FFFC, 1'b0);
    check(!r_fault && r_pa == 32'h9999_FFFC, "R9 large page from last slot", r_pa, 32'h9999_FFFC);
  endtask

  task automatic t_l2_fault();
    walk(32'h3005_0040, 1'b1);
    check(r_fault && r_reads == 2, "R6 level-two fault", {r_fault, 31'(r_reads)}, 32'h8000_0002);
    check(r_fva == 32'h3005_0040 && r_fwr, "R6 fault address", r_fva, 32'h3005_0040);
  endtask

  task automatic t_busy_slow();
    int r0;
    logic got = 1'b0;
    mlat = 4;
    r0 = rd_count;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'h2003_4ABC; req_write = 1'b0;
    @(negedge clk);
    check(busy, "R10 busy after accept", {31'b0, busy}, 32'h1);
    req_vaddr = 32'h1234_5678;     // presented while busy
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 500 && !got; i++) begin
      if (done) begin got = 1'b1; r_pa = done_paddr; end
      else @(negedge clk);
    end
    check(got && r_pa == 32'h7777_7ABC, "R11 slow memory walk", r_pa, 32'h7777_7ABC);
    check(rd_count - r0 == 2, "R11 read count", rd_count - r0, 2);
    for (int i = 0; i < 8; i++) @(negedge clk);
    check(!busy && rd_count - r0 == 2, "R10 request while busy ignored", rd_count - r0, 2);
    mlat = 1;
  endtask

  initial begin
    ptbase = 32'h0001_0000;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_section();
    t_l1_fault();
    t_small();
    t_large();
    t_l2_fault();
    t_busy_slow();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule